// File: doc/BRIEF.md
# Frame-Synchronised Serial Sample Port

This block sends converter samples to a host over a three-wire serial port. It produces a bit clock (`dclk_o`), a frame strobe (`fsync_o`) and serial data (`dout_o`), all as registered functions of the single port clock `clk_i`. Sample words arrive on a parallel bus with a valid strobe and are held until the next frame begins. Each frame then shifts one word out, most significant bit first.

At every frame start the block latches two settings. A 2-bit divider code sets the bit-clock period. A half-frame length, counted in bit-clock periods, sets the frame length. The frame strobe is high for the first half of each frame and low for the second half, and it rises together with a falling bit-clock edge. After reset is released the port runs a fixed warm-up and then signals that it is ready. After that a level control input, `start_i`, starts the frame stream and stops it. Stopping follows a fixed sequence: the bit clock halts first, and the strobe and data halt a few cycles later.

In the text below, an "edge" is a rising edge of `clk_i`. Every latency is counted in edges.

Top module: `fsync_port`

## Requirements
- R1: While `rst_ni` is low, `dclk_o`, `fsync_o` and `dout_o` are all low, and they go low as soon as reset is asserted.
- R2: After reset is released, `fsync_o` is high from edge 1 through edge READY_LAT-1 (default 104). It goes low at edge READY_LAT, which marks the port as ready. `dclk_o` and `dout_o` stay low for this whole warm-up, and `start_i` has no effect during it.
- R3: For divider code c (0..3), `dclk_o` has a period of 2^(c+1) clock cycles with a 50% duty cycle, and it is low in the first half of each period, starting at the frame start.
- R4: For half-frame length h, a frame lasts 2·h bit-clock periods. `fsync_o` is high for the first h periods and low for the rest. It rises on the same edge at which `dclk_o` falls, or at which `dclk_o` starts.
- R5: `dout_o` carries the word MSB first, one bit per bit-clock period, and it changes only when `dclk_o` falls. Bit positions at or beyond WORD_W (default 24) are driven low. The configuration must satisfy 2·h ≥ WORD_W.
- R6: A word presented with `sample_valid_i` at an edge is stored in a holding register. The next frame start loads that register into the shifter, and the frame that is already shifting finishes with its old word. If no new word arrives, the previous word is sent again.
- R7: If `start_i` is sampled low at edge P while frames run, `dclk_o` is low from edge P+DCLK_STOP_LAT-1 onward (default 7 edges after the fall) and `dout_o` holds its value from that point. At edge P+FSYNC_STOP_LAT-1 (default 11 edges after the fall), `fsync_o` and `dout_o` become low and the port is idle.
- R8: While the port is idle and ready, with `start_i` low, all outputs are low. The first edge that samples `start_i` high begins a new frame: `fsync_o` goes high, `dclk_o` is low, and `dout_o` shows the MSB of the held word, using the divider and length settings present at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Port timing clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Run (high) / stop (low) control |
| sample_i | input | WORD_W | Parallel sample word |
| sample_valid_i | input | 1 | Captures `sample_i` into the holding register |
| cfg_div_i | input | SEL_W | Bit-clock divider code, latched at frame start |
| cfg_half_i | input | HALF_W | Half-frame length in bit-clock periods, latched at frame start |
| dclk_o | output | 1 | Serial bit clock |
| fsync_o | output | 1 | Frame strobe, or the busy level during warm-up |
| dout_o | output | 1 | Serial data, valid on rising `dclk_o` |

## Verification
A wrong phase or bit counter shows up on the pins within one bit-clock period. It appears as a stretched or shortened `dclk_o` half, a strobe edge that misses a falling bit-clock edge, or a data bit out of place. All three are compared on every clock cycle against a timing model built from elapsed cycles since frame start. A wrong sequencer count moves the warm-up fall or the stop edges off their fixed edge numbers, which shows within a dozen cycles of the event. A wrong holding-register hand-off becomes visible at the first bit of the following frame.

// File: rtl/fsp_pkg.sv
package fsp_pkg;

    typedef enum logic [1:0] {
        SEQ_WARM = 2'd0,
        SEQ_IDLE = 2'd1,
        SEQ_RUN  = 2'd2,
        SEQ_HALT = 2'd3
    } seq_state_e;

endpackage

// File: rtl/fsp_seq.sv
// Port sequencer: warm-up after reset, idle/run control and the halt sequence.
module fsp_seq
    import fsp_pkg::*;
#(
    parameter int READY_LAT      = 104,
    parameter int DCLK_STOP_LAT  = 7,
    parameter int FSYNC_STOP_LAT = 11
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    output logic launch_o,
    output logic advance_o,
    output logic dclk_en_o,
    output logic out_en_o,
    output logic warm_fs_o
);

    localparam int MAXC  = (READY_LAT > FSYNC_STOP_LAT) ? READY_LAT : FSYNC_STOP_LAT;
    localparam int CNT_W = $clog2(MAXC + 1);

    typedef struct packed {
        seq_state_e       st;
        logic [CNT_W-1:0] cnt;
        logic             dclk_en;
        logic             out_en;
        logic             warm_fs;
    } seq_regs_t;

    seq_regs_t        seq_d, seq_q;
    logic [CNT_W-1:0] cnt_inc;

    always_comb begin
        seq_d    = seq_q;
        launch_o = 1'b0;
        cnt_inc  = seq_q.cnt + 1'b1;
        unique case (seq_q.st)
            SEQ_WARM: begin
                seq_d.cnt = cnt_inc;
                if (cnt_inc == CNT_W'(READY_LAT)) begin
                    seq_d.st      = SEQ_IDLE;
                    seq_d.warm_fs = 1'b0;
                    seq_d.cnt     = '0;
                end else begin
                    seq_d.warm_fs = 1'b1;
                end
            end
            SEQ_IDLE: begin
                if (start_i) begin
                    launch_o      = 1'b1;
                    seq_d.st      = SEQ_RUN;
                    seq_d.dclk_en = 1'b1;
                    seq_d.out_en  = 1'b1;
                end
            end
            SEQ_RUN: begin
                if (!start_i) begin
                    seq_d.st  = SEQ_HALT;
                    seq_d.cnt = CNT_W'(1);
                end
            end
            SEQ_HALT: begin
                seq_d.cnt = cnt_inc;
                if (cnt_inc >= CNT_W'(DCLK_STOP_LAT)) begin
                    seq_d.dclk_en = 1'b0;
                end
                if (cnt_inc >= CNT_W'(FSYNC_STOP_LAT)) begin
                    seq_d.st      = SEQ_IDLE;
                    seq_d.out_en  = 1'b0;
                    seq_d.dclk_en = 1'b0;
                    seq_d.cnt     = '0;
                end
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            seq_q <= '{st: SEQ_WARM, cnt: '0, dclk_en: 1'b0, out_en: 1'b0, warm_fs: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign advance_o = (seq_q.st == SEQ_RUN) || (seq_q.st == SEQ_HALT);
    assign dclk_en_o = seq_q.dclk_en;
    assign out_en_o  = seq_q.out_en;
    assign warm_fs_o = seq_q.warm_fs;

endmodule

// File: rtl/fsp_clkgen.sv
// Bit-clock generator: half-period phase counter and clock level.
module fsp_clkgen #(
    parameter int SEL_W = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             launch_i,
    input  logic             advance_i,
    input  logic [SEL_W-1:0] div_sel_i,
    output logic             level_o,
    output logic             fall_o
);

    localparam int PH_W = (1 << SEL_W) - 1;

    typedef struct packed {
        logic [PH_W-1:0] ph;
        logic            lvl;
    } clk_regs_t;

    clk_regs_t       clk_d, clk_q;
    logic [PH_W-1:0] ph_last;
    logic            half_end;

    always_comb begin
        clk_d    = clk_q;
        ph_last  = PH_W'((1 << div_sel_i) - 1);
        half_end = (clk_q.ph == ph_last);
        fall_o   = advance_i && half_end && clk_q.lvl;
        if (launch_i) begin
            clk_d.ph  = '0;
            clk_d.lvl = 1'b0;
        end else if (advance_i) begin
            if (half_end) begin
                clk_d.ph  = '0;
                clk_d.lvl = !clk_q.lvl;
            end else begin
                clk_d.ph = clk_q.ph + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            clk_q <= '0;
        end else begin
            clk_q <= clk_d;
        end
    end

    assign level_o = clk_q.lvl;

endmodule

// File: rtl/fsp_framer.sv
// Frame timing: bit counter, frame strobe and per-frame configuration latch.
module fsp_framer #(
    parameter int SEL_W  = 2,
    parameter int HALF_W = 6
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              launch_i,
    input  logic              fall_i,
    input  logic [SEL_W-1:0]  cfg_div_i,
    input  logic [HALF_W-1:0] cfg_half_i,
    output logic [SEL_W-1:0]  div_sel_o,
    output logic              fsync_o,
    output logic              wrap_o
);

    localparam int BIT_W = HALF_W + 1;

    typedef struct packed {
        logic [BIT_W-1:0]  bitn;
        logic [HALF_W-1:0] half;
        logic [SEL_W-1:0]  sel;
        logic              fs;
    } frm_regs_t;

    frm_regs_t        frm_d, frm_q;
    logic [BIT_W-1:0] frame_last;
    logic [BIT_W-1:0] bit_inc;

    always_comb begin
        frm_d      = frm_q;
        frame_last = {frm_q.half, 1'b0} - 1'b1;
        bit_inc    = frm_q.bitn + 1'b1;
        wrap_o     = fall_i && (frm_q.bitn == frame_last);
        if (launch_i || wrap_o) begin
            frm_d.bitn = '0;
            frm_d.half = cfg_half_i;
            frm_d.sel  = cfg_div_i;
            frm_d.fs   = 1'b1;
        end else if (fall_i) begin
            frm_d.bitn = bit_inc;
            frm_d.fs   = (bit_inc < {1'b0, frm_q.half});
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            frm_q <= '0;
        end else begin
            frm_q <= frm_d;
        end
    end

    assign div_sel_o = frm_q.sel;
    assign fsync_o   = frm_q.fs;

endmodule

// File: rtl/fsp_shifter.sv
// Sample holding register and MSB-first output shifter with zero fill.
module fsp_shifter #(
    parameter int WORD_W = 24
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [WORD_W-1:0] sample_i,
    input  logic              valid_i,
    input  logic              load_i,
    input  logic              shift_i,
    output logic              dout_o
);

    typedef struct packed {
        logic [WORD_W-1:0] pend;
        logic [WORD_W-1:0] sr;
        logic              dout;
    } sh_regs_t;

    sh_regs_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (valid_i) begin
            sh_d.pend = sample_i;
        end
        if (load_i) begin
            sh_d.sr   = sh_q.pend;
            sh_d.dout = sh_q.pend[WORD_W-1];
        end else if (shift_i) begin
            sh_d.sr   = sh_q.sr << 1;
            sh_d.dout = sh_q.sr[WORD_W-2];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign dout_o = sh_q.dout;

endmodule

// File: rtl/fsync_port.sv
// Frame-synchronised serial sample port: top level.
module fsync_port #(
    parameter int WORD_W         = 24,
    parameter int SEL_W          = 2,
    parameter int HALF_W         = 6,
    parameter int READY_LAT      = 104,
    parameter int DCLK_STOP_LAT  = 7,
    parameter int FSYNC_STOP_LAT = 11
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic [WORD_W-1:0] sample_i,
    input  logic              sample_valid_i,
    input  logic [SEL_W-1:0]  cfg_div_i,
    input  logic [HALF_W-1:0] cfg_half_i,
    output logic              dclk_o,
    output logic              fsync_o,
    output logic              dout_o
);

    logic             launch, advance, dclk_en, out_en, warm_fs;
    logic             level, fall, wrap, frame_fs, data_bit;
    logic [SEL_W-1:0] div_sel;
    logic             sh_load, sh_shift;

    fsp_seq #(
        .READY_LAT      (READY_LAT),
        .DCLK_STOP_LAT  (DCLK_STOP_LAT),
        .FSYNC_STOP_LAT (FSYNC_STOP_LAT)
    ) u_seq (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .start_i   (start_i),
        .launch_o  (launch),
        .advance_o (advance),
        .dclk_en_o (dclk_en),
        .out_en_o  (out_en),
        .warm_fs_o (warm_fs)
    );

    fsp_clkgen #(
        .SEL_W (SEL_W)
    ) u_clkgen (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .launch_i  (launch),
        .advance_i (advance),
        .div_sel_i (div_sel),
        .level_o   (level),
        .fall_o    (fall)
    );

    fsp_framer #(
        .SEL_W  (SEL_W),
        .HALF_W (HALF_W)
    ) u_framer (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .launch_i   (launch),
        .fall_i     (fall),
        .cfg_div_i  (cfg_div_i),
        .cfg_half_i (cfg_half_i),
        .div_sel_o  (div_sel),
        .fsync_o    (frame_fs),
        .wrap_o     (wrap)
    );

    // Data freezes once the bit clock is gated off during a halt.
    assign sh_load  = launch || (wrap && dclk_en);
    assign sh_shift = fall && dclk_en;

    fsp_shifter #(
        .WORD_W (WORD_W)
    ) u_shifter (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .sample_i (sample_i),
        .valid_i  (sample_valid_i),
        .load_i   (sh_load),
        .shift_i  (sh_shift),
        .dout_o   (data_bit)
    );

    assign dclk_o  = level && dclk_en;
    assign fsync_o = (frame_fs && out_en) || warm_fs;
    assign dout_o  = data_bit && out_en;

endmodule

// File: rtl/fsync_port_chk.sv
// Timing checker bound to the port top level.
module fsync_port_chk #(
    parameter int READY_LAT      = 104,
    parameter int DCLK_STOP_LAT  = 7,
    parameter int FSYNC_STOP_LAT = 11
) (
    input logic clk_i,
    input logic rst_ni,
    input logic start_i,
    input logic dclk_o,
    input logic fsync_o,
    input logic dout_o
);

    localparam int SINCE_W = $clog2(READY_LAT + 2);
    localparam int LOW_W   = $clog2(FSYNC_STOP_LAT + 1);

    logic [SINCE_W-1:0] since_q;
    logic [LOW_W-1:0]   low_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            since_q <= '0;
            low_q   <= '0;
        end else begin
            if (since_q <= SINCE_W'(READY_LAT)) begin
                since_q <= since_q + 1'b1;
            end
            if (start_i) begin
                low_q <= '0;
            end else if (low_q < LOW_W'(FSYNC_STOP_LAT)) begin
                low_q <= low_q + 1'b1;
            end
        end
    end

    // R2
    warm_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (since_q >= SINCE_W'(1) && since_q < SINCE_W'(READY_LAT)) |-> (fsync_o && !dclk_o && !dout_o));

    // R2
    ready_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (since_q == SINCE_W'(READY_LAT)) |-> !fsync_o);

    // R4
    frame_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(fsync_o) |-> !dclk_o);

    // R5
    dout_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (low_q == '0 && !$stable(dout_o)) |-> ($fell(dclk_o) || $rose(fsync_o)));

    // R7
    dclk_halt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (low_q >= LOW_W'(DCLK_STOP_LAT)) |-> !dclk_o);

    // R7
    out_halt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (low_q >= LOW_W'(FSYNC_STOP_LAT) && since_q > SINCE_W'(READY_LAT)) |-> (!fsync_o && !dout_o));

endmodule

bind fsync_port fsync_port_chk #(
    .READY_LAT      (READY_LAT),
    .DCLK_STOP_LAT  (DCLK_STOP_LAT),
    .FSYNC_STOP_LAT (FSYNC_STOP_LAT)
) i_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .dclk_o  (dclk_o),
    .fsync_o (fsync_o),
    .dout_o  (dout_o)
);

// File: tb/test_fsync_port.sv
module test_fsync_port;

    localparam int W     = 24;
    localparam int READY = 104;
    localparam int DSTOP = 7;
    localparam int FSTOP = 11;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b1;
    logic         valid = 1'b0;
    logic [W-1:0] sample = '0;
    logic [1:0]   sel = 2'd0;
    logic [5:0]   half = 6'd12;
    logic         dclk, fsync, dout;

    int errors = 0;
    int checks = 0;
    logic [W-1:0] pend = '0;

    always #10 clk = ~clk;

    fsync_port i_fsync_port (
        .clk_i          (clk),
        .rst_ni         (rst_n),
        .start_i        (start),
        .sample_i       (sample),
        .sample_valid_i (valid),
        .cfg_div_i      (sel),
        .cfg_half_i     (half),
        .dclk_o         (dclk),
        .fsync_o        (fsync),
        .dout_o         (dout)
    );

    task automatic check(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s at %0t: actual %b expected %b", req, what, $time, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Expected {dclk, fsync, dout} m cycles after the frame-start edge.
    function automatic logic [2:0] model(input int m, input int h, input int hf, input logic [W-1:0] wd);
        int p, k, b, ph;
        p  = 2 * h;
        k  = m / p;
        b  = k % (2 * hf);
        ph = m % p;
        return {ph >= h, b < hf, (b < W) ? wd[W-1-b] : 1'b0};
    endfunction

    task automatic segment(input int s, input int hf, input int nfr, input bit from_warm);
        int h, fl, md, skip, j;
        logic [W-1:0] cur;
        logic [2:0]   exp;
        logic         frozen;
        h      = 1 << s;
        fl     = 2 * h * 2 * hf;
        cur    = '0;
        frozen = 1'b0;
        sel    = 2'(s);
        half   = 6'(hf);
        if (!from_warm) begin
            sample = W'($urandom);
            valid  = 1'b1;
            tick();
            valid = 1'b0;
            pend  = sample;
            // R8: idle and ready with start low
            check("R8", "idle dclk", dclk, 1'b0);
            check("R8", "idle fsync", fsync, 1'b0);
            check("R8", "idle dout", dout, 1'b0);
            start = 1'b1;
        end
        md   = (nfr - 1) * fl + int'($urandom_range(fl - 1));
        skip = int'($urandom_range(nfr - 1));
        for (int m = 0; m <= md + FSTOP + 3; m++) begin
            tick();
            if (valid) begin
                valid = 1'b0;
                pend  = sample;
            end
            if (m % fl == 0) cur = pend;
            exp = model(m, h, hf, cur);
            j = m - md;
            if (m > md && j >= FSTOP) begin
                exp = 3'b000;
            end else if (m > md && j > DSTOP) begin
                exp[2] = 1'b0;
                exp[0] = frozen;
            end else if (m > md && j == DSTOP) begin
                exp[2] = 1'b0;
                frozen = exp[0];
            end
            if (m > md && j >= DSTOP) begin
                // R7: halt sequence
                check("R7", "dclk halt", dclk, exp[2]);
                check(j >= FSTOP ? "R7" : "R4", "fsync halt", fsync, exp[1]);
                check("R7", "dout halt", dout, exp[0]);
            end else begin
                check("R3", "dclk", dclk, exp[2]);
                check(m == 0 && !from_warm ? "R8" : "R4", "fsync", fsync, exp[1]);
                check(m % fl == 0 ? "R6" : "R5", "dout", dout, exp[0]);
            end
            if (m == md) begin
                start = 1'b0;
            end else if (m < md && (m % fl) == fl / 2 && (m / fl) != skip) begin
                sample = W'($urandom);
                valid  = 1'b1;
            end
        end
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog expired: actual hung expected finished");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        check("R1", "reset dclk", dclk, 1'b0);
        check("R1", "reset fsync", fsync, 1'b0);
        check("R1", "reset dout", dout, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        // R2: warm-up busy level, then ready fall; start high is ignored
        for (int k = 1; k <= READY; k++) begin
            tick();
            if (k == 40) begin
                sample = W'($urandom);
                valid  = 1'b1;
            end else if (k == 41) begin
                valid = 1'b0;
                pend  = sample;
            end
            check("R2", "warm fsync", fsync, (k < READY) ? 1'b1 : 1'b0);
            check("R2", "warm dclk", dclk, 1'b0);
            check("R2", "warm dout", dout, 1'b0);
        end
        segment(0, 12, 3, 1'b1);
        // directed corners: slowest clock, exact fit and padded frame
        segment(3, 12, 2, 1'b0);
        segment(1, 16, 3, 1'b0);
        segment(2, 13, 2, 1'b0);
        for (int r = 0; r < 5; r++) begin
            segment(int'($urandom_range(3)), 12 + int'($urandom_range(4)),
                    2 + int'($urandom_range(1)), 1'b0);
        end
        // R1: reset asserted while running
        start = 1'b1;
        repeat (6) tick();
        rst_n = 1'b0;
        #1;
        check("R1", "mid-run reset dclk", dclk, 1'b0);
        check("R1", "mid-run reset fsync", fsync, 1'b0);
        check("R1", "mid-run reset dout", dout, 1'b0);
        repeat (2) tick();
        check("R1", "held reset fsync", fsync, 1'b0);
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule